// File: doc/BRIEF.md
# SPI Command-Framed UART Register Interface

This block is the host-side front end of a UART. A host reaches it as an SPI slave over fixed 16-bit frames. The two most significant bits of each frame select one of four operations: load a line configuration, read that configuration back, queue a transmit character, or fetch a received character. While the host shifts its command in, the block shifts a status or data word out on the same frame. Bits 15 and 14 of that word are always the receive-available and transmit-empty flags.

The serial line engines, the baud generator and the receive FIFO storage are outside this block. The interface reaches them through one-cycle strobes: transmit load, receive pop and configuration clear. It also reads their status inputs. The four interrupt mask bits of a configuration word take effect as soon as its 16th bit arrives. The line settings (FIFO disable, sleep request, IrDA timing, two stop bits, parity enable, 7-bit length, baud select) are held pending until the transmitter reports idle. All SPI pins and the clear-to-send input are synchronised into the system clock domain. SCLK must therefore run well below the system clock.

Top module: `spi_uart_regif`

## Requirements
- R1: A frame is 16 bits, most significant first. The input is captured on rising SCLK edges while chip-select is low. The output bit changes after falling SCLK edges, and bit 15 is presented soon after chip-select falls.
- R2: Frame bits 15:14 select the operation: 11 writes the configuration, 01 reads the configuration, 10 writes data, 00 reads data. At most one of the transmit-load, receive-pop and configuration-clear strobes is high in any cycle.
- R3: If chip-select rises before 16 bits have been captured, no register, mask, RTS bit or strobe is affected. The next chip-select fall starts a new frame.
- R4: In every frame, output bits 15 and 14 carry `rx_avail_i` and `tx_empty_i` as sampled when chip-select fell.
- R5: The mask bits of a configuration frame (bits 11:8, driven on `irq_mask_o[3:0]` in that order) take effect right after the 16th rising SCLK edge, before chip-select rises.
- R6: A configuration frame's line fields are bit 13 FIFO off, bit 12 sleep request, bit 7 IrDA, bit 6 two stop bits, bit 5 parity enable, bit 4 7-bit length and bits 3:0 baud select. They reach the `cfg_*` outputs only once `tx_idle_i` is high after the frame completes.
- R7: A completed configuration frame gives a one-cycle `cfg_clr_o` pulse after chip-select rises, and it leaves the RTS bit unchanged.
- R8: A completed data-write frame with bit 10 = 0 gives a one-cycle `tx_load_o` pulse carrying bits 7:0 on `tx_data_o` and bit 8 on `tx_par_o`. It also sets the RTS bit to frame bit 9, and `rts_n_o` is the inverse of the RTS bit (high after reset).
- R9: A data-write frame with bit 10 = 1 updates only the RTS bit and gives no load pulse.
- R10: A data-read frame returns `rx_err_i` at bit 10, the inverse of `cts_n_i` at bit 9, `rx_par_i` at bit 8 and `rx_data_i` at bits 7:0. Bits 13:11 are zero. A completed data-read frame gives a one-cycle `rx_pop_o` pulse.
- R11: A configuration-read frame returns the last configuration written, even while it is still pending, in the same bit positions as R6. Bits 11:8 hold the current masks and bit 12 holds `shdn_stat_i` in place of the sleep request.
- R12: A completed configuration-read frame sets `test_mode_o` to frame bit 0.
- R13: While chip-select is high, `spi_miso_oe_o` and `spi_miso_o` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n_i | input | 1 | SPI chip-select, active low |
| spi_sclk_i | input | 1 | SPI serial clock |
| spi_mosi_i | input | 1 | SPI data from host |
| spi_miso_o | output | 1 | SPI data to host (register standing in for the pad) |
| spi_miso_oe_o | output | 1 | Output enable for the MISO pad |
| cts_n_i | input | 1 | Clear-to-send pin, active low |
| rts_n_o | output | 1 | Request-to-send pin, active low |
| rx_avail_i | input | 1 | Receive data available flag |
| tx_empty_i | input | 1 | Transmit buffer empty flag |
| tx_idle_i | input | 1 | Transmitter has no character in flight |
| rx_err_i | input | 1 | Receive framing-error / activity flag |
| rx_par_i | input | 1 | Parity bit of oldest received word |
| rx_data_i | input | 8 | Oldest received data word |
| shdn_stat_i | input | 1 | Shutdown status for readback |
| tx_load_o | output | 1 | One-cycle transmit load strobe |
| tx_data_o | output | 8 | Data for the transmitter |
| tx_par_o | output | 1 | Parity bit for the transmitter |
| rx_pop_o | output | 1 | One-cycle receive pop strobe |
| cfg_clr_o | output | 1 | One-cycle clear strobe on configuration write |
| cfg_fifo_off_o | output | 1 | Applied FIFO disable |
| cfg_sleep_o | output | 1 | Applied sleep request |
| cfg_irda_o | output | 1 | Applied IrDA timing select |
| cfg_stop2_o | output | 1 | Applied two-stop-bit select |
| cfg_par_en_o | output | 1 | Applied parity enable |
| cfg_len7_o | output | 1 | Applied 7-bit word length |
| cfg_baud_o | output | 4 | Applied baud select |
| irq_mask_o | output | 4 | Interrupt masks {tx-empty, rx-avail, parity, error} |
| test_mode_o | output | 1 | Test mode select |

## Verification
A wrong bit counter or a wrong operation register shows up in the frame itself. Bits returned from bit 13 onward come back misplaced or zero. A mis-decoded commit pulses the wrong strobe within a few cycles of chip-select rising. A pending-configuration flag that is stuck or cleared early shows on the `cfg_*` outputs: they change while `tx_idle_i` is low, or they never follow it. The bench therefore holds the transmitter busy across a configuration write and checks the outputs on both sides of the idle transition. An abort path that leaks state shows up after the next full frame, as moved masks, RTS or strobe counts.

// File: rtl/spi_regif_pkg.sv
package spi_regif_pkg;

  localparam int FRAME_W = 16;
  localparam int DATA_W  = 8;

  typedef enum logic [1:0] {
    OP_RDAT = 2'b00,
    OP_RCFG = 2'b01,
    OP_WDAT = 2'b10,
    OP_WCFG = 2'b11
  } op_e;

  typedef struct packed {
    logic       fifo_off;
    logic       sleep;
    logic       irda;
    logic       stop2;
    logic       par_en;
    logic       len7;
    logic [3:0] baud;
  } line_cfg_t;

  function automatic line_cfg_t cfg_from_word(input logic [FRAME_W-1:0] w);
    line_cfg_t c;
    c.fifo_off = w[13];
    c.sleep    = w[12];
    c.irda     = w[7];
    c.stop2    = w[6];
    c.par_en   = w[5];
    c.len7     = w[4];
    c.baud     = w[3:0];
    return c;
  endfunction

endpackage

// File: rtl/regif_sync.sv
module regif_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  localparam int CHAIN_W = W * STAGES;

  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[CHAIN_W-W-1:0], d_i};
  end

  assign q_o = chain_q[CHAIN_W-1 -: W];

endmodule

// File: rtl/regif_frame_rx.sv
module regif_frame_rx
  import spi_regif_pkg::*;
#(
  parameter int FW = FRAME_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n_s,
  input  logic          sclk_s,
  input  logic          mosi_s,
  output logic          start_o,
  output logic          end_o,
  output logic          fall_o,
  output logic          full_o,
  output logic          last_o,
  output logic          op_ev_o,
  output op_e           op_o,
  output logic [FW-1:0] word_o
);

  localparam int CNT_W = $clog2(FW + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FW);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FW - 1);
  localparam logic [CNT_W-1:0] CNT_OP   = CNT_W'(1);

  logic             cs_n_d, sclk_d;
  logic [CNT_W-1:0] bit_cnt_q, bit_cnt_n;
  logic [FW-1:0]    word_q, word_n;
  op_e              op_q, op_n;
  logic             op_ev_q, op_ev_n;
  logic             last_q, last_n;
  logic             start, endp, rise, fall;

  always_comb begin
    start     = cs_n_d & ~cs_n_s;
    endp      = ~cs_n_d & cs_n_s;
    rise      = ~cs_n_s & sclk_s & ~sclk_d;
    fall      = ~cs_n_s & ~sclk_s & sclk_d;
    bit_cnt_n = bit_cnt_q;
    word_n    = word_q;
    op_n      = op_q;
    op_ev_n   = 1'b0;
    last_n    = 1'b0;
    if (start) begin
      bit_cnt_n = '0;
    end else if (rise && (bit_cnt_q < CNT_FULL)) begin
      word_n    = {word_q[FW-2:0], mosi_s};
      bit_cnt_n = bit_cnt_q + CNT_W'(1);
      if (bit_cnt_q == CNT_OP) begin
        op_n    = op_e'({word_q[0], mosi_s});
        op_ev_n = 1'b1;
      end
      last_n = (bit_cnt_q == CNT_LAST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_d    <= 1'b1;
      sclk_d    <= 1'b0;
      bit_cnt_q <= '0;
      word_q    <= '0;
      op_q      <= OP_RDAT;
      op_ev_q   <= 1'b0;
      last_q    <= 1'b0;
    end else begin
      cs_n_d    <= cs_n_s;
      sclk_d    <= sclk_s;
      bit_cnt_q <= bit_cnt_n;
      word_q    <= word_n;
      op_q      <= op_n;
      op_ev_q   <= op_ev_n;
      last_q    <= last_n;
    end
  end

  assign start_o = start;
  assign end_o   = endp;
  assign fall_o  = fall;
  assign full_o  = (bit_cnt_q == CNT_FULL);
  assign last_o  = last_q;
  assign op_ev_o = op_ev_q;
  assign op_o    = op_q;
  assign word_o  = word_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt_q <= CNT_FULL); // R1

  AST_LAST_MAKES_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    last_q |-> full_o); // R1

endmodule

// File: rtl/regif_cfg.sv
module regif_cfg
  import spi_regif_pkg::*;
#(
  parameter int MASK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_we,
  input  logic [MASK_W-1:0] mask_d,
  input  logic              cfg_we,
  input  line_cfg_t         cfg_d,
  input  logic              tst_we,
  input  logic              tst_d,
  input  logic              tx_idle_i,
  output line_cfg_t         cfg_wr_o,
  output line_cfg_t         cfg_act_o,
  output logic [MASK_W-1:0] mask_o,
  output logic              test_o
);

  line_cfg_t         wr_q, wr_n, act_q, act_n;
  logic              pend_q, pend_n;
  logic [MASK_W-1:0] mask_q, mask_n;
  logic              test_q, test_n;

  always_comb begin
    wr_n   = wr_q;
    act_n  = act_q;
    pend_n = pend_q;
    mask_n = mask_q;
    test_n = test_q;
    if (pend_q && tx_idle_i) begin
      act_n  = wr_q;
      pend_n = 1'b0;
    end
    if (cfg_we) begin
      wr_n   = cfg_d;
      pend_n = 1'b1;
    end
    if (mask_we) mask_n = mask_d;
    if (tst_we)  test_n = tst_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      act_q  <= '0;
      pend_q <= 1'b0;
      mask_q <= '0;
      test_q <= 1'b0;
    end else begin
      wr_q   <= wr_n;
      act_q  <= act_n;
      pend_q <= pend_n;
      mask_q <= mask_n;
      test_q <= test_n;
    end
  end

  assign cfg_wr_o  = wr_q;
  assign cfg_act_o = act_q;
  assign mask_o    = mask_q;
  assign test_o    = test_q;

  AST_CFG_WAITS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q != $past(act_q)) |-> $past(tx_idle_i)); // R6

  AST_MASK_ONLY_ON_WE: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q != $past(mask_q)) |-> $past(mask_we)); // R5

endmodule

// File: rtl/spi_uart_regif.sv
module spi_uart_regif
  import spi_regif_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n_i,
  input  logic              spi_sclk_i,
  input  logic              spi_mosi_i,
  output logic              spi_miso_o,
  output logic              spi_miso_oe_o,
  input  logic              cts_n_i,
  output logic              rts_n_o,
  input  logic              rx_avail_i,
  input  logic              tx_empty_i,
  input  logic              tx_idle_i,
  input  logic              rx_err_i,
  input  logic              rx_par_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              shdn_stat_i,
  output logic              tx_load_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_par_o,
  output logic              rx_pop_o,
  output logic              cfg_clr_o,
  output logic              cfg_fifo_off_o,
  output logic              cfg_sleep_o,
  output logic              cfg_irda_o,
  output logic              cfg_stop2_o,
  output logic              cfg_par_en_o,
  output logic              cfg_len7_o,
  output logic [3:0]        cfg_baud_o,
  output logic [3:0]        irq_mask_o,
  output logic              test_mode_o
);

  localparam int PAY_W = FRAME_W - 2;
  localparam int FC_W  = $clog2(FRAME_W);
  localparam logic [FC_W-1:0] FC_LAST = FC_W'(FRAME_W - 1);
  localparam logic [FC_W-1:0] FC_TOP  = FC_W'(FRAME_W - 2);

  // synchronised pins: {cs_n, sclk, mosi, cts_n}
  logic [3:0] sync_q;
  logic       cs_n_s, sclk_s, mosi_s, cts_n_s;

  regif_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({spi_cs_n_i, spi_sclk_i, spi_mosi_i, cts_n_i}),
    .q_o   (sync_q)
  );
  assign cs_n_s  = sync_q[3];
  assign sclk_s  = sync_q[2];
  assign mosi_s  = sync_q[1];
  assign cts_n_s = sync_q[0];

  logic               frm_start, frm_end, frm_fall, frm_full, frm_last, op_ev;
  op_e                op_cur;
  logic [FRAME_W-1:0] frm_word;

  regif_frame_rx #(.FW(FRAME_W)) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n_s  (cs_n_s),
    .sclk_s  (sclk_s),
    .mosi_s  (mosi_s),
    .start_o (frm_start),
    .end_o   (frm_end),
    .fall_o  (frm_fall),
    .full_o  (frm_full),
    .last_o  (frm_last),
    .op_ev_o (op_ev),
    .op_o    (op_cur),
    .word_o  (frm_word)
  );

  op_e       cmt_op;
  logic      cmt_ok, cmt_wcfg, cmt_rcfg, cmt_wdat, cmt_rdat;
  logic      mask_we;
  line_cfg_t cfg_wr, cfg_act;
  logic [3:0] mask_cur;

  always_comb begin
    cmt_op   = op_e'(frm_word[FRAME_W-1 -: 2]);
    cmt_ok   = frm_end & frm_full;
    cmt_wcfg = cmt_ok && (cmt_op == OP_WCFG);
    cmt_rcfg = cmt_ok && (cmt_op == OP_RCFG);
    cmt_wdat = cmt_ok && (cmt_op == OP_WDAT);
    cmt_rdat = cmt_ok && (cmt_op == OP_RDAT);
    mask_we  = frm_last && (cmt_op == OP_WCFG);
  end

  regif_cfg #(.MASK_W(4)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask_we   (mask_we),
    .mask_d    (frm_word[11:8]),
    .cfg_we    (cmt_wcfg),
    .cfg_d     (cfg_from_word(frm_word)),
    .tst_we    (cmt_rcfg),
    .tst_d     (frm_word[0]),
    .tx_idle_i (tx_idle_i),
    .cfg_wr_o  (cfg_wr),
    .cfg_act_o (cfg_act),
    .mask_o    (mask_cur),
    .test_o    (test_mode_o)
  );

  // reply word, MISO shifter and commit strobes
  logic [FRAME_W-1:0] out_q, out_n;
  logic [FC_W-1:0]    fcnt_q, fcnt_n;
  logic               miso_q, miso_n, oe_q, oe_n, rts_q, rts_n;
  logic               load_q, load_n, pop_q, pop_n, clr_q, clr_n;
  logic [DATA_W-1:0]  txd_q, txd_n;
  logic               txp_q, txp_n;
  logic [PAY_W-1:0]   payload;

  always_comb begin
    unique case (op_cur)
      OP_RDAT: payload = {3'b000, rx_err_i, ~cts_n_s, rx_par_i, rx_data_i};
      OP_RCFG: payload = {cfg_wr.fifo_off, shdn_stat_i, mask_cur, cfg_wr.irda,
                          cfg_wr.stop2, cfg_wr.par_en, cfg_wr.len7, cfg_wr.baud};
      default: payload = '0;
    endcase
  end

  always_comb begin
    out_n  = out_q;
    fcnt_n = fcnt_q;
    miso_n = miso_q;
    oe_n   = oe_q;
    rts_n  = rts_q;
    txd_n  = txd_q;
    txp_n  = txp_q;
    load_n = cmt_wdat & ~frm_word[10];
    pop_n  = cmt_rdat;
    clr_n  = cmt_wcfg;
    if (frm_start) begin
      out_n  = {rx_avail_i, tx_empty_i, {PAY_W{1'b0}}};
      miso_n = rx_avail_i;
      fcnt_n = '0;
      oe_n   = 1'b1;
    end else if (frm_end) begin
      miso_n = 1'b0;
      oe_n   = 1'b0;
    end else begin
      if (op_ev) out_n[PAY_W-1:0] = payload;
      if (frm_fall && (fcnt_q < FC_LAST)) begin
        miso_n = out_q[FC_TOP - fcnt_q];
        fcnt_n = fcnt_q + FC_W'(1);
      end
    end
    if (cmt_wdat) rts_n = frm_word[9];
    if (load_n) begin
      txd_n = frm_word[DATA_W-1:0];
      txp_n = frm_word[8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      fcnt_q <= '0;
      miso_q <= 1'b0;
      oe_q   <= 1'b0;
      rts_q  <= 1'b0;
      txd_q  <= '0;
      txp_q  <= 1'b0;
      load_q <= 1'b0;
      pop_q  <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      out_q  <= out_n;
      fcnt_q <= fcnt_n;
      miso_q <= miso_n;
      oe_q   <= oe_n;
      rts_q  <= rts_n;
      txd_q  <= txd_n;
      txp_q  <= txp_n;
      load_q <= load_n;
      pop_q  <= pop_n;
      clr_q  <= clr_n;
    end
  end

  assign spi_miso_o     = miso_q;
  assign spi_miso_oe_o  = oe_q;
  assign rts_n_o        = ~rts_q;
  assign tx_load_o      = load_q;
  assign tx_data_o      = txd_q;
  assign tx_par_o       = txp_q;
  assign rx_pop_o       = pop_q;
  assign cfg_clr_o      = clr_q;
  assign cfg_fifo_off_o = cfg_act.fifo_off;
  assign cfg_sleep_o    = cfg_act.sleep;
  assign cfg_irda_o     = cfg_act.irda;
  assign cfg_stop2_o    = cfg_act.stop2;
  assign cfg_par_en_o   = cfg_act.par_en;
  assign cfg_len7_o     = cfg_act.len7;
  assign cfg_baud_o     = cfg_act.baud;
  assign irq_mask_o     = mask_cur;

  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_load_o, rx_pop_o, cfg_clr_o})); // R2

  AST_STROBE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load_o || rx_pop_o || cfg_clr_o) |-> !spi_miso_oe_o); // R3

  AST_RTS_ONLY_ON_WDAT: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_n_o != $past(rts_n_o)) |-> $past(cmt_wdat)); // R9

  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_miso_oe_o |-> !spi_miso_o); // R13

  AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load_o |=> !tx_load_o); // R8

endmodule

// File: tb/spi_uart_regif_test.sv
module spi_uart_regif_test;

  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       spi_cs_n_i, spi_sclk_i, spi_mosi_i, spi_miso_o, spi_miso_oe_o;
  logic       cts_n_i, rts_n_o;
  logic       rx_avail_i, tx_empty_i, tx_idle_i, rx_err_i, rx_par_i, shdn_stat_i;
  logic [7:0] rx_data_i, tx_data_o;
  logic       tx_load_o, tx_par_o, rx_pop_o, cfg_clr_o;
  logic       cfg_fifo_off_o, cfg_sleep_o, cfg_irda_o, cfg_stop2_o, cfg_par_en_o, cfg_len7_o;
  logic [3:0] cfg_baud_o, irq_mask_o;
  logic       test_mode_o;

  int checks = 0, failures = 0;
  int load_cnt = 0, pop_cnt = 0, clr_cnt = 0;
  logic [7:0] last_data;
  logic       last_par;
  bit         finished = 0;

  always #4 clk = ~clk;

  spi_uart_regif uut (
    .clk(clk), .rst_n(rst_n),
    .spi_cs_n_i(spi_cs_n_i), .spi_sclk_i(spi_sclk_i), .spi_mosi_i(spi_mosi_i),
    .spi_miso_o(spi_miso_o), .spi_miso_oe_o(spi_miso_oe_o),
    .cts_n_i(cts_n_i), .rts_n_o(rts_n_o),
    .rx_avail_i(rx_avail_i), .tx_empty_i(tx_empty_i), .tx_idle_i(tx_idle_i),
    .rx_err_i(rx_err_i), .rx_par_i(rx_par_i), .rx_data_i(rx_data_i),
    .shdn_stat_i(shdn_stat_i),
    .tx_load_o(tx_load_o), .tx_data_o(tx_data_o), .tx_par_o(tx_par_o),
    .rx_pop_o(rx_pop_o), .cfg_clr_o(cfg_clr_o),
    .cfg_fifo_off_o(cfg_fifo_off_o), .cfg_sleep_o(cfg_sleep_o), .cfg_irda_o(cfg_irda_o),
    .cfg_stop2_o(cfg_stop2_o), .cfg_par_en_o(cfg_par_en_o), .cfg_len7_o(cfg_len7_o),
    .cfg_baud_o(cfg_baud_o), .irq_mask_o(irq_mask_o), .test_mode_o(test_mode_o)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      if (tx_load_o) begin
        load_cnt  <= load_cnt + 1;
        last_data <= tx_data_o;
        last_par  <= tx_par_o;
      end
      if (rx_pop_o)  pop_cnt <= pop_cnt + 1;
      if (cfg_clr_o) clr_cnt <= clr_cnt + 1;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cs_begin();
    spi_cs_n_i = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_end();
    spi_cs_n_i = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic shift(input logic [15:0] w, input int n, output logic [15:0] r);
    r = '0;
    for (int i = 0; i < n; i++) begin
      spi_mosi_i = w[15-i];
      wait_clk(HALF);
      r[15-i] = spi_miso_o;
      spi_sclk_i = 1'b1;
      wait_clk(HALF);
      spi_sclk_i = 1'b0;
    end
    wait_clk(HALF);
  endtask

  task automatic frame(input logic [15:0] w, output logic [15:0] r);
    cs_begin();
    shift(w, 16, r);
    cs_end();
  endtask

  task automatic t_reset();
    chk("R13 miso idle", spi_miso_o, 0);
    chk("R13 oe idle", spi_miso_oe_o, 0);
    chk("R8 rts_n reset", rts_n_o, 1);
    chk("R6 baud reset", cfg_baud_o, 0);
    chk("R5 mask reset", irq_mask_o, 0);
    chk("R12 test reset", test_mode_o, 0);
  endtask

  task automatic t_cfg_deferred();
    logic [15:0] r;
    int c0;
    c0 = clr_cnt;
    tx_idle_i = 1'b0; rx_avail_i = 1'b1; tx_empty_i = 1'b0; shdn_stat_i = 1'b1;
    cs_begin();
    chk("R13 oe active", spi_miso_oe_o, 1);
    shift(16'hCAE5, 16, r);
    wait_clk(HALF);
    chk("R5 mask before release", irq_mask_o, 4'b1010);
    chk("R6 baud held mid", cfg_baud_o, 0);
    cs_end();
    chk("R4 status bits", r[15:14], 2'b10);
    chk("R7 clear pulse", clr_cnt - c0, 1);
    chk("R6 baud held busy", cfg_baud_o, 0);
    chk("R6 irda held busy", cfg_irda_o, 0);
    frame(16'h4000, r);
    chk("R11 readback pending", r, 16'h9AE5);
    tx_idle_i = 1'b1;
    wait_clk(4);
    chk("R6 baud applied", cfg_baud_o, 4'h5);
    chk("R6 line bits applied",
        {cfg_fifo_off_o, cfg_sleep_o, cfg_irda_o, cfg_stop2_o, cfg_par_en_o, cfg_len7_o},
        6'b001110);
  endtask

  task automatic t_wdata();
    logic [15:0] r;
    int l0;
    l0 = load_cnt;
    rx_avail_i = 1'b0; tx_empty_i = 1'b1;
    frame(16'h83A5, r);
    chk("R4 status wdata", r, 16'h4000);
    chk("R8 one load", load_cnt - l0, 1);
    chk("R8 data", last_data, 8'hA5);
    chk("R8 parity", last_par, 1);
    chk("R8 rts set", rts_n_o, 0);
    frame(16'h843C, r);
    chk("R9 no load te", load_cnt - l0, 1);
    chk("R9 rts cleared", rts_n_o, 1);
  endtask

  task automatic t_rdata();
    logic [15:0] r;
    int p0;
    p0 = pop_cnt;
    rx_avail_i = 1'b1; tx_empty_i = 1'b1; rx_err_i = 1'b1; cts_n_i = 1'b0;
    rx_par_i = 1'b0; rx_data_i = 8'h5A;
    wait_clk(4);
    frame(16'h0000, r);
    chk("R10 R1 read word a", r, 16'hC65A);
    chk("R10 pop", pop_cnt - p0, 1);
    rx_err_i = 1'b0; cts_n_i = 1'b1; rx_par_i = 1'b1; rx_data_i = 8'h81;
    wait_clk(4);
    frame(16'h0000, r);
    chk("R10 R1 read word b", r, 16'hC181);
    chk("R10 pop two", pop_cnt - p0, 2);
  endtask

  task automatic t_abort();
    logic [15:0] r;
    int c0, l0;
    frame(16'h8600, r);
    chk("R9 rts via te", rts_n_o, 0);
    c0 = clr_cnt; l0 = load_cnt;
    cs_begin(); shift(16'hFFFF, 10, r); cs_end();
    chk("R3 mask kept", irq_mask_o, 4'b1010);
    chk("R3 baud kept", cfg_baud_o, 4'h5);
    chk("R3 no clear", clr_cnt - c0, 0);
    cs_begin(); shift(16'h81FF, 12, r); cs_end();
    chk("R3 no load", load_cnt - l0, 0);
    chk("R3 rts kept", rts_n_o, 0);
    frame(16'hC000, r);
    wait_clk(4);
    chk("R2 wcfg after abort", {irq_mask_o, cfg_baud_o}, 8'h00);
    chk("R7 clear once", clr_cnt - c0, 1);
    chk("R7 rts preserved", rts_n_o, 0);
  endtask

  task automatic t_test_mode();
    logic [15:0] r;
    frame(16'h4001, r);
    chk("R12 test on", test_mode_o, 1);
    frame(16'h4000, r);
    chk("R12 test off", test_mode_o, 0);
    chk("R13 idle after frames", {spi_miso_oe_o, spi_miso_o}, 2'b00);
  endtask

  initial begin
    rst_n = 1'b0;
    spi_cs_n_i = 1'b1; spi_sclk_i = 1'b0; spi_mosi_i = 1'b0;
    cts_n_i = 1'b1; rx_avail_i = 1'b0; tx_empty_i = 1'b1; tx_idle_i = 1'b1;
    rx_err_i = 1'b0; rx_par_i = 1'b0; rx_data_i = 8'h00; shdn_stat_i = 1'b0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_cfg_deferred();
    t_wdata();
    t_rdata();
    t_abort();
    t_test_mode();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule